// File: doc/BRIEF.md
# AC Bias Toggle and Interrupt Counter

This block drives the polarity-inversion output of a passive display panel. It counts line-clock pulses and flips the bias output once every programmed number of line clocks. The panel uses that output to reverse its supply polarity at regular intervals so that no DC charge builds up. Every flip of the bias output is a toggle event. A second counter tallies toggle events. After a programmed number of them it sets a sticky status flag, which raises an interrupt request.

In active-panel mode the bias output is held low. The toggle events still reach the transition counter, so the pair of counters then acts as a periodic line-count interrupt. When the panel does not use the bias output, software sets the period to its largest value (0xFF) to reduce switching. There is no data stream at this block's edge, so every pin is a plain level or single-cycle pulse and none uses valid/ready.

Top module: `ac_bias_ctrl`

## Requirements
- R1: After reset, `bias_out`, `status` and `irq` are all 0, and the line-clock count starts at zero.
- R2: In passive mode (`passive_mode`=1) with period field P, `bias_out` inverts on every (P+1)-th line-clock pulse and on no other cycle. After the k-th pulse since reset it equals floor(k/(P+1)) mod 2. Cycles without a `line_pulse` change nothing.
- R3: In active mode (`passive_mode`=0), `bias_out` stays 0. Toggle events keep occurring internally at the R2 rate.
- R4: In active mode, toggle events still advance the transition counter. The status flag is set after N×(P+1) line-clock pulses.
- R5: With transition limit N in 1..15, `status` goes to 1 in the same clock edge that completes the N-th toggle event since the counter last started. It stays 1 until cleared.
- R6: While `status` is 1, the transition counter is frozen. A `status_clr` pulse clears `status` and restarts the count from zero, so exactly N further toggle events are needed to set it again.
- R7: With N = 0, the transition counter stays at zero and `status` never becomes set.
- R8: If `status_clr` and the N-th toggle event fall in the same cycle, the clear wins. `status` ends at 0 and the count restarts from zero.
- R9: The period field is sampled at the first line-clock pulse of each bias period. A change made during a period takes effect only after that period's terminal count.
- R10: `irq` equals `status` while N is non-zero. `irq` is 0 while N is 0, even if `status` is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pulse | input | 1 | One-cycle pulse per line clock |
| passive_mode | input | 1 | 1 = passive panel (bias output driven), 0 = active panel |
| period | input | 8 | Bias toggle period field P (toggle every P+1 line clocks) |
| trans_limit | input | 4 | Toggle events per interrupt N, 0 disables |
| status_clr | input | 1 | One-cycle software clear of the status flag |
| bias_out | output | 1 | Polarity-inversion output to the panel |
| status | output | 1 | Sticky transition-count status flag |
| irq | output | 1 | Interrupt request |

## Verification
A period counter in the wrong state moves the next bias edge. That error shows on `bias_out` at the next expected terminal pulse, at most P+1 line clocks later. A wrong transition count shifts the rise of `status` and `irq` by whole toggle events. It becomes visible within N toggle events of the last clear or reset. Faults in the freeze or clear-priority logic show up as `status` rising one toggle event early or late after a clear, so the sweeps count events exactly around each clear.

// File: rtl/acb_pkg.sv
package acb_pkg;
  typedef enum logic {
    ACB_ACTIVE  = 1'b0,
    ACB_PASSIVE = 1'b1
  } acb_mode_e;

  localparam int unsigned ACB_PERIOD_W = 8;
  localparam int unsigned ACB_LIMIT_W  = 4;
endpackage

// File: rtl/ac_bias_period.sv
module ac_bias_period #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_pulse,
  input  logic [PW-1:0] period_in,
  output logic          toggle_ev,
  output logic          bias_q
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] shadow_q;
  logic [PW-1:0] cur_period;

  // period is sampled on the first pulse of a period (count at zero)
  assign cur_period = (cnt_q == '0) ? period_in : shadow_q;
  assign toggle_ev  = line_pulse && (cnt_q == cur_period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      bias_q   <= 1'b0;
    end else if (line_pulse) begin
      if (cnt_q == '0) shadow_q <= period_in;
      cnt_q <= toggle_ev ? '0 : cnt_q + 1'b1;
      if (toggle_ev) bias_q <= ~bias_q;
    end
  end

  // R2
  bias_only_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bias_q) |-> $past(line_pulse));

  // R2
  count_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_pulse |=> $stable(cnt_q));
endmodule

// File: rtl/ac_bias_irq.sv
module ac_bias_irq #(
  parameter int unsigned NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          toggle_ev,
  input  logic [NW-1:0] limit_in,
  input  logic          status_clr,
  output logic          status_q
);
  logic [NW-1:0] tcnt_q;
  logic          enabled;
  logic          last_ev;

  assign enabled = (limit_in != '0);
  // >= keeps the count bounded if the limit is lowered below it
  assign last_ev = enabled && (tcnt_q >= limit_in - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt_q   <= '0;
      status_q <= 1'b0;
    end else if (status_clr) begin
      tcnt_q   <= '0;
      status_q <= 1'b0;
    end else if (!enabled) begin
      tcnt_q <= '0;
    end else if (!status_q && toggle_ev) begin
      if (last_ev) begin
        tcnt_q   <= '0;
        status_q <= 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // R5
  status_rise_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(toggle_ev) && !$past(status_clr));

  // R6
  frozen_while_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q && !status_clr |=> $stable(tcnt_q) && status_q);

  // R7
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_in == '0) && !status_q |=> !status_q);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |=> !status_q && (tcnt_q == '0));
endmodule

// File: rtl/ac_bias_ctrl.sv
module ac_bias_ctrl
  import acb_pkg::*;
#(
  parameter int unsigned PERIOD_W = ACB_PERIOD_W,
  parameter int unsigned LIMIT_W  = ACB_LIMIT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_pulse,
  input  logic                passive_mode,
  input  logic [PERIOD_W-1:0] period,
  input  logic [LIMIT_W-1:0]  trans_limit,
  input  logic                status_clr,
  output logic                bias_out,
  output logic                status,
  output logic                irq
);
  acb_mode_e mode;
  logic      toggle_ev;
  logic      bias_q;

  assign mode = acb_mode_e'(passive_mode);

  ac_bias_period #(.PW(PERIOD_W)) i_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_pulse (line_pulse),
    .period_in  (period),
    .toggle_ev  (toggle_ev),
    .bias_q     (bias_q)
  );

  ac_bias_irq #(.NW(LIMIT_W)) i_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .toggle_ev  (toggle_ev),
    .limit_in   (trans_limit),
    .status_clr (status_clr),
    .status_q   (status)
  );

  assign bias_out = (mode == ACB_PASSIVE) ? bias_q : 1'b0;
  assign irq      = status && (trans_limit != '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !status && !bias_q);

  // R3
  active_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !passive_mode |-> !bias_out);
endmodule

// File: tb/test_ac_bias_ctrl.sv
module test_ac_bias_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_pulse = 1'b0;
  logic       passive_mode = 1'b1;
  logic [7:0] period = 8'd0;
  logic [3:0] trans_limit = 4'd0;
  logic       status_clr = 1'b0;
  logic       bias_out, status, irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ac_bias_ctrl i_ac_bias_ctrl (
    .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
    .passive_mode(passive_mode), .period(period), .trans_limit(trans_limit),
    .status_clr(status_clr), .bias_out(bias_out), .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; line_pulse = 1'b0; status_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one line pulse, then idle gap cycles; outputs sampled after it
  task automatic pulse(input int gap, input logic clr);
    @(negedge clk);
    line_pulse = 1'b1; status_clr = clr;
    @(negedge clk);
    line_pulse = 1'b0; status_clr = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int plist[6] = '{0, 1, 2, 3, 7, 255};
    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 bias", bias_out, 1'b0);
    check("R1 status", status, 1'b0);
    check("R1 irq", irq, 1'b0);

    // R2 period sweep, passive, irregular gaps; R7 with N=0
    foreach (plist[i]) begin
      period = plist[i][7:0]; trans_limit = 4'd0; passive_mode = 1'b1;
      do_reset();
      for (int k = 1; k <= 2 * (plist[i] + 1) + 1; k++) begin
        pulse(k % 3, 1'b0);
        check("R2 toggle", bias_out, logic'((k / (plist[i] + 1)) % 2));
      end
      check("R7 disabled", status, 1'b0);
    end

    // R5/R6 limit sweep with P=1 (a toggle every 2 pulses)
    for (int n = 1; n <= 15; n++) begin
      period = 8'd1; trans_limit = n[3:0]; passive_mode = 1'b1;
      do_reset();
      for (int t = 1; t <= n; t++) begin
        pulse(0, 1'b0);
        check("R5 mid", status, 1'b0);
        pulse(1, 1'b0);
        check("R5 set", status, logic'(t >= n));
        check("R10 irq", irq, logic'(t >= n));
      end
      for (int t = 0; t < 6; t++) pulse(0, 1'b0);
      check("R6 frozen", status, 1'b1);
      clear();
      check("R6 cleared", status, 1'b0);
      for (int t = 1; t <= n; t++) begin
        pulse(0, 1'b0); pulse(0, 1'b0);
        check("R6 restart", status, logic'(t >= n));
      end
    end

    // R3/R4 active mode
    period = 8'd2; trans_limit = 4'd3; passive_mode = 1'b0;
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      pulse(1, 1'b0);
      check("R3 low", bias_out, 1'b0);
      check("R4 status", status, logic'(k >= 9));
    end

    // R8 clear coincides with terminal event
    period = 8'd0; trans_limit = 4'd2; passive_mode = 1'b1;
    do_reset();
    pulse(0, 1'b0);
    pulse(0, 1'b1);
    check("R8 clear wins", status, 1'b0);
    pulse(0, 1'b0);
    check("R8 restart one", status, 1'b0);
    pulse(0, 1'b0);
    check("R8 restart two", status, 1'b1);

    // R9 period change mid-period
    period = 8'd3; trans_limit = 4'd0;
    do_reset();
    pulse(0, 1'b0);
    period = 8'd0;
    pulse(0, 1'b0); check("R9 old period", bias_out, 1'b0);
    pulse(0, 1'b0); check("R9 old period", bias_out, 1'b0);
    pulse(0, 1'b0); check("R9 terminal", bias_out, 1'b1);
    pulse(0, 1'b0); check("R9 new period", bias_out, 1'b0);
    pulse(0, 1'b0); check("R9 new period", bias_out, 1'b1);

    // R10 irq masked by zero limit
    period = 8'd0; trans_limit = 4'd2;
    do_reset();
    pulse(0, 1'b0); pulse(0, 1'b0);
    check("R10 irq on", irq, 1'b1);
    @(negedge clk); trans_limit = 4'd0;
    @(negedge clk);
    check("R10 irq masked", irq, 1'b0);
    check("R10 status kept", status, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule